// File: doc/BRIEF.md
# Converter Output Test Pattern Generator

This block sits on the sample path behind a data converter. For each sample that arrives with its valid strobe, it emits one output word one clock later. The output is either the live sample with a signed offset added, or a word from a selected test pattern. The patterns are fixed codes, a checkerboard, a word toggle, a ramp, two pseudo-random sequences, and a four-word user sequence that either repeats or plays once and then holds zero.

Configuration arrives as plain register-style inputs: a 4-bit pattern select, a 2-bit user cycle mode, four user words, a hold control for each pseudo-random generator, and a 6-bit signed offset. Output words are two's complement, `DW` bits wide (default 14).

Top module: `adc_pattern_gen`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` equals `smp_valid` delayed by one clock. While `smp_valid` is 0, `out_data` holds its value and no pattern position advances.
- R3: When `pat_sel` is 0000, or any code from 1001 to 1110, the output is `smp_data` plus `offset` (6-bit two's complement, −32..+31). The sum saturates at 0x1FFF and 0x2000 (for DW=14) instead of wrapping.
- R4: Code 0001 gives 0. Code 0010 gives the largest positive code (0x1FFF). Code 0011 gives the most negative code (0x2000).
- R5: Code 0100 alternates 0x2AAA and 0x1555 on each sample, starting with 0x2AAA.
- R6: Code 0111 alternates all ones (0x3FFF) and all zeros on each sample, starting with all ones.
- R7: Code 1111 gives a ramp that starts at 0, rises by 1 per sample, and wraps from 0x3FFF to 0.
- R8: Code 1000 with `user_cycle` 00, 01 or 11 gives `user_w0`, `user_w1`, `user_w2`, `user_w3` in that order and then repeats.
- R9: Code 1000 with `user_cycle` 10 gives the four user words once and then 0 on every later sample.
- R10: Code 0101 outputs the top DW bits of a 23-bit shift register for x^23+x^18+1. The feedback is bit22 XOR bit17, shifted in at bit 0. The register advances once per valid sample. While `pn_long_hold` is 1, the register is held at all ones.
- R11: Code 0110 outputs the 9-bit register for x^9+x^5+1. The feedback is bit8 XOR bit4. The register sits at the top of the output word and the bits below it are 0. It advances once per valid sample. While `pn_short_hold` is 1, the register is held at all ones.
- R12: Any change of `pat_sel` or `user_cycle` restarts the pattern position. This covers the checkerboard and toggle phase, the ramp value, the user word index and the single-play state. The restart applies to the sample taken at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Live sample strobe |
| smp_data | input | DW | Live sample, two's complement |
| pat_sel | input | 4 | Pattern select |
| user_cycle | input | 2 | User sequence mode (10 = play once) |
| user_w0 | input | DW | User word 1 |
| user_w1 | input | DW | User word 2 |
| user_w2 | input | DW | User word 3 |
| user_w3 | input | DW | User word 4 |
| pn_long_hold | input | 1 | Hold long PN generator at seed |
| pn_short_hold | input | 1 | Hold short PN generator at seed |
| offset | input | 6 | Signed offset for live data |
| out_valid | output | 1 | Output word strobe |
| out_data | output | DW | Output word |

## Verification
Two events can land on the same clock edge. A write of the select or the cycle mode can arrive with a valid sample, and then the restart and the first word of the new pattern must resolve together. A generator hold can be released as the first sample of its sequence is drawn. The bench changes `pat_sel` or `user_cycle` at the same falling edge where a sample is held valid, including one change in the middle of a user sequence. It then checks that the first word out is the start of the new sequence (0, 0x2AAA, all ones, or `user_w0`) and not a continuation of the old one. For the generators, the hold is dropped with the sample strobe already high, and the first word must be the all-ones seed before any shift.

// File: rtl/adc_pattern_gen.sv
module adc_pattern_gen #(
  parameter int DW = 14,
  parameter int OW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic [3:0]    pat_sel,
  input  logic [1:0]    user_cycle,
  input  logic [DW-1:0] user_w0,
  input  logic [DW-1:0] user_w1,
  input  logic [DW-1:0] user_w2,
  input  logic [DW-1:0] user_w3,
  input  logic          pn_long_hold,
  input  logic          pn_short_hold,
  input  logic [OW-1:0] offset,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int LW = 23;
  localparam int SW = 9;
  localparam logic [DW-1:0]   POS_FS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0]   NEG_FS = {1'b1, {(DW-1){1'b0}}};
  localparam logic [2*DW-1:0] CHK_PAIR = {DW{2'b10}};
  localparam logic [DW-1:0]   CHK_A = CHK_PAIR[DW-1:0];

  logic [3:0]    sel_q;
  logic [1:0]    cyc_q;
  logic [DW-1:0] step_q;
  logic          done_q;
  logic [LW-1:0] pn_l;
  logic [SW-1:0] pn_s;
  logic [DW-1:0] pn_l_word, pn_s_word, user_word, word;

  wire restart = (pat_sel != sel_q) || (user_cycle != cyc_q);
  wire [DW-1:0] step = restart ? '0 : step_q;
  wire done   = !restart && done_q;
  wire single = (user_cycle == 2'b10);

  wire [DW:0] sum = {smp_data[DW-1], smp_data} + {{(DW+1-OW){offset[OW-1]}}, offset};
  wire [DW-1:0] live = (!sum[DW] &&  sum[DW-1]) ? POS_FS :
                       ( sum[DW] && !sum[DW-1]) ? NEG_FS : sum[DW-1:0];

  if (DW <= LW) begin : g_l_top
    assign pn_l_word = pn_l[LW-1 -: DW];
  end else begin : g_l_pad
    assign pn_l_word = {pn_l, {(DW-LW){1'b0}}};
  end
  if (DW <= SW) begin : g_s_top
    assign pn_s_word = pn_s[SW-1 -: DW];
  end else begin : g_s_pad
    assign pn_s_word = {pn_s, {(DW-SW){1'b0}}};
  end

  always_comb begin
    case (step[1:0])
      2'd0:    user_word = user_w0;
      2'd1:    user_word = user_w1;
      2'd2:    user_word = user_w2;
      default: user_word = user_w3;
    endcase
  end

  always_comb begin
    case (pat_sel)
      4'b0001: word = '0;
      4'b0010: word = POS_FS;
      4'b0011: word = NEG_FS;
      4'b0100: word = step[0] ? ~CHK_A : CHK_A;
      4'b0101: word = pn_l_word;
      4'b0110: word = pn_s_word;
      4'b0111: word = step[0] ? '0 : '1;
      4'b1000: word = (single && done) ? '0 : user_word;
      4'b1111: word = step;
      default: word = live;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= '0;
      cyc_q     <= '0;
      step_q    <= '0;
      done_q    <= 1'b0;
      pn_l      <= '1;
      pn_s      <= '1;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      sel_q     <= pat_sel;
      cyc_q     <= user_cycle;
      out_valid <= smp_valid;
      step_q    <= smp_valid ? step + 1'b1 : step;
      done_q    <= done || (smp_valid && single && step[1:0] == 2'd3);
      if (smp_valid) out_data <= word;
      if (pn_long_hold)   pn_l <= '1;
      else if (smp_valid) pn_l <= {pn_l[LW-2:0], pn_l[22] ^ pn_l[17]};
      if (pn_short_hold)  pn_s <= '1;
      else if (smp_valid) pn_s <= {pn_s[SW-2:0], pn_s[8] ^ pn_s[4]};
    end
  end
endmodule

// File: rtl/adc_pattern_gen_chk.sv
module adc_pattern_gen_chk #(
  parameter int DW = 14,
  parameter int OW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic [DW-1:0] smp_data,
  input logic [3:0]    pat_sel,
  input logic [1:0]    user_cycle,
  input logic [OW-1:0] offset,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          done_q
);
  localparam logic [DW-1:0] POS_FS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_FS = {1'b1, {(DW-1){1'b0}}};

  // R1
  reset_state_chk: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_data == '0));
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) smp_valid |=> out_valid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) !smp_valid |=> !out_valid);
  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !smp_valid |=> $stable(out_data));
  // R3
  pos_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && pat_sel == 4'b0000 && smp_data == POS_FS && !offset[OW-1]) |=> out_data == POS_FS);
  // R3
  neg_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && pat_sel == 4'b0000 && smp_data == NEG_FS && offset[OW-1]) |=> out_data == NEG_FS);
  // R4
  full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && pat_sel == 4'b0010) |=> out_data == POS_FS);
  // R9
  single_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && pat_sel == 4'b1000 && user_cycle == 2'b10 && done_q && $stable(pat_sel) && $stable(user_cycle))
    |=> out_data == '0);
endmodule

bind adc_pattern_gen adc_pattern_gen_chk #(.DW(DW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
  .pat_sel(pat_sel), .user_cycle(user_cycle), .offset(offset),
  .out_valid(out_valid), .out_data(out_data), .done_q(done_q)
);

// File: tb/adc_pattern_gen_tb.sv
module adc_pattern_gen_tb;
  localparam int DW = 14;
  localparam int NV = 10;
  // {smp_data, offset, expected}
  localparam logic [33:0] VEC [NV] = '{
    {14'd100,  6'd0,   14'd100},
    {14'd100,  6'd5,   14'd105},
    {14'd100,  6'h20,  14'd68},
    {14'h1FFF, 6'd1,   14'h1FFF},
    {14'h1FF0, 6'h1F,  14'h1FFF},
    {14'h2000, 6'h3F,  14'h2000},
    {14'h2010, 6'h20,  14'h2000},
    {14'h3FFF, 6'd1,   14'h0000},
    {14'h1FE0, 6'h1F,  14'h1FFF},
    {14'd5,    6'h3B,  14'h0000}
  };

  logic clk = 0, rst_n = 0, smp_valid = 0;
  logic [DW-1:0] smp_data = '0;
  logic [3:0] pat_sel = '0;
  logic [1:0] user_cycle = '0;
  logic [DW-1:0] user_w0 = 14'h0111, user_w1 = 14'h0222, user_w2 = 14'h0333, user_w3 = 14'h0444;
  logic pn_long_hold = 1, pn_short_hold = 1;
  logic [5:0] offset = '0;
  logic out_valid;
  logic [DW-1:0] out_data;
  int checks = 0, errors = 0, cycles = 0;
  bit ended = 0;
  logic [22:0] ml;
  logic [8:0] ms;
  logic [DW-1:0] held;

  always #10 clk = ~clk;

  adc_pattern_gen #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .pat_sel(pat_sel), .user_cycle(user_cycle), .user_w0(user_w0), .user_w1(user_w1),
    .user_w2(user_w2), .user_w3(user_w3), .pn_long_hold(pn_long_hold),
    .pn_short_hold(pn_short_hold), .offset(offset), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic report;
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !ended) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      report();
    end
  end

  initial begin
    smp_valid = 1;
    repeat (3) @(negedge clk);
    chk({13'd0, out_valid}, 14'd0, "R1 valid in reset");
    chk(out_data, 14'd0, "R1 data in reset");
    rst_n = 1;

    // R3 table walk (normal and unused codes)
    for (int i = 0; i < NV; i++) begin
      pat_sel  = (i % 3 == 2) ? 4'b1100 : 4'b0000;
      smp_data = VEC[i][33:20];
      offset   = VEC[i][19:14];
      @(negedge clk);
      chk(out_data, VEC[i][13:0], $sformatf("R3 vector %0d", i));
    end
    chk({13'd0, out_valid}, 14'd1, "R2 valid follows");

    // R4 constant codes
    pat_sel = 4'b0001; @(negedge clk); chk(out_data, 14'h0000, "R4 midscale");
    pat_sel = 4'b0010; @(negedge clk); chk(out_data, 14'h1FFF, "R4 positive full scale");
    pat_sel = 4'b0011; @(negedge clk); chk(out_data, 14'h2000, "R4 negative full scale");

    // R5 checkerboard, R12 restart at change
    pat_sel = 4'b0100;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); chk(out_data, k[0] ? 14'h1555 : 14'h2AAA, "R5 R12 checkerboard");
    end
    // R6 toggle
    pat_sel = 4'b0111;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); chk(out_data, k[0] ? 14'h0000 : 14'h3FFF, "R6 word toggle");
    end

    // R7 ramp with a gap (R2)
    pat_sel = 4'b1111;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); chk(out_data, k[DW-1:0], "R7 ramp");
    end
    smp_valid = 0; held = out_data;
    @(negedge clk);
    chk({13'd0, out_valid}, 14'd0, "R2 valid drops");
    chk(out_data, held, "R2 data held");
    smp_valid = 1;
    @(negedge clk); chk(out_data, 14'd20, "R2 R7 no advance in gap");
    repeat (16383 - 21) @(negedge clk);
    @(negedge clk); chk(out_data, 14'h3FFF, "R7 ramp top");
    @(negedge clk); chk(out_data, 14'h0000, "R7 ramp wrap");

    // R8 user repeat
    pat_sel = 4'b1000; user_cycle = 2'b00;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(out_data, (k % 4 == 0) ? user_w0 : (k % 4 == 1) ? user_w1 : (k % 4 == 2) ? user_w2 : user_w3, "R8 repeat 00");
    end
    @(negedge clk); chk(out_data, user_w0, "R8 index");
    user_cycle = 2'b11;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(out_data, (k % 4 == 0) ? user_w0 : (k % 4 == 1) ? user_w1 : (k % 4 == 2) ? user_w2 : user_w3, "R8 R12 repeat 11 restart");
    end
    user_cycle = 2'b01;
    @(negedge clk); chk(out_data, user_w0, "R8 R12 repeat 01");

    // R9 single play
    user_cycle = 2'b10;
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      chk(out_data, (k == 0) ? user_w0 : (k == 1) ? user_w1 : (k == 2) ? user_w2 : (k == 3) ? user_w3 : 14'h0000, "R9 single play");
    end
    pat_sel = 4'b0001; @(negedge clk);
    pat_sel = 4'b1000; @(negedge clk); chk(out_data, user_w0, "R12 single restart");

    // R10 long PN
    pat_sel = 4'b0101; @(negedge clk);
    pn_long_hold = 0; ml = '1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); chk(out_data, ml[22:9], "R10 long PN");
      ml = {ml[21:0], ml[22] ^ ml[17]};
    end
    pn_long_hold = 1;
    repeat (2) @(negedge clk); chk(out_data, 14'h3FFF, "R10 long hold");

    // R11 short PN
    pat_sel = 4'b0110; @(negedge clk);
    pn_short_hold = 0; ms = '1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); chk(out_data, {ms, 5'b0}, "R11 short PN");
      ms = {ms[7:0], ms[8] ^ ms[4]};
    end
    pn_short_hold = 1;
    repeat (2) @(negedge clk); chk(out_data, 14'h3FE0, "R11 short hold");

    report();
  end
endmodule